// File: doc/BRIEF.md
# Background Integer Multiply-Divide Unit

This unit performs integer multiplication and division over many clock cycles, next to the main pipeline and not inside it. A caller issues a one-cycle start with an operation code, a width mode and two operands. The unit then works through the operation one bit per cycle while other instructions keep flowing. When it finishes, it places the results in two private 64-bit result registers, HI and LO. A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI.

Callers read HI and LO directly from the output ports. While an operation is running, `busy_o` is high and a reader must wait for it to fall. Software can also load HI and LO directly through a write port. Issuing a new start while an operation runs throws away the old operation and begins the new one.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hi_o` and `lo_o` read zero and `busy_o` is low.
- R2: `op_i` selects the operation: 2'b00 unsigned multiply, 2'b01 signed multiply, 2'b10 unsigned divide, 2'b11 signed divide. `wide_i`=1 selects 64-bit mode (N=64) and 0 selects 32-bit mode (N=32). `busy_o` rises in the cycle after a start and stays high for exactly N+1 cycles. The new HI/LO values are visible as soon as `busy_o` is low again.
- R3: A multiply writes the upper N bits of the 2N-bit product to HI and the lower N bits to LO. The signed multiply treats both operands as two's complement.
- R4: A divide writes the quotient to LO and the remainder to HI. For a signed divide, the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R5: In 32-bit mode, only bits [31:0] of each operand are used, and each 32-bit result is sign-extended to 64 bits, even for the unsigned operations.
- R6: A divide whose divisor is zero in the selected width completes with the normal latency. It leaves all ones in LO and the dividend in HI (sign-extended from bit 31 in 32-bit mode).
- R7: While `busy_o` is high, HI and LO keep their values, and any direct write requested during that time is ignored.
- R8: With `busy_o` low, `hi_wr_i` loads `wr_data_i` into HI and `lo_wr_i` loads it into LO, both visible one cycle later. A write that arrives together with `start_i` is ignored.
- R9: A start while `busy_o` is high abandons the running operation without writing HI or LO. It restarts, and `busy_o` then stays high for the full N+1 cycles of the new operation, which alone determines the result.
- R10: A signed divide of the most negative N-bit value by -1 yields that same most negative value (sign-extended) in LO and zero in HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command to begin an operation |
| op_i | input | 2 | Operation code (see R2) |
| wide_i | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| opa_i | input | 64 | Multiplicand or dividend |
| opb_i | input | 64 | Multiplier or divisor |
| hi_wr_i | input | 1 | Direct write strobe for HI |
| lo_wr_i | input | 1 | Direct write strobe for LO |
| wr_data_i | input | 64 | Data for direct writes |
| busy_o | output | 1 | Operation in progress; HI/LO reads must wait |
| hi_o | output | 64 | HI result register |
| lo_o | output | 64 | LO result register |

## Verification
The hardest situations to reach from the ports are a restart that lands partway through a running operation and write strobes that arrive while the unit is busy. Only the command and timing at the ports decide whether the old result is dropped and the strobes are ignored. The stimulus issues a decoy operation of the opposite kind and width, then replaces it after a random number of cycles. It also fires write strobes mid-operation and together with a start. Operand pickers are biased toward zero, one, all ones and the most negative value, so that divide-by-zero and signed overflow occur within the random run as well as in the directed cases.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam int DW = 64;

  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;

  function automatic logic fn_is_div(md_op_e op);
    return (op == OP_DIVU) || (op == OP_DIVS);
  endfunction

  function automatic logic fn_is_signed(md_op_e op);
    return (op == OP_MULS) || (op == OP_DIVS);
  endfunction

endpackage

// File: rtl/muldiv_mul_engine.sv
module muldiv_mul_engine #(
  parameter int W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       cancel_i,
  input  logic [$clog2(W+1)-1:0]     iters_i,
  input  logic [W-1:0]               mcand_i,
  input  logic [W-1:0]               mplier_i,
  output logic                       active_o,
  output logic                       fin_o,
  output logic [2*W-1:0]             prod_o
);
  localparam int CW = $clog2(W+1);

  logic [2*W-1:0] acc_q, mc_q;
  logic [W-1:0]   mp_q;
  logic [CW-1:0]  cnt_q;
  logic           act_q;

  // one multiplier bit consumed per cycle, multiplicand walks left
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      acc_q <= '0;
      mc_q  <= {{W{1'b0}}, mcand_i};
      mp_q  <= mplier_i;
      cnt_q <= iters_i;
      act_q <= 1'b1;
    end else if (cancel_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (cnt_q != '0) begin
        if (mp_q[0]) acc_q <= acc_q + mc_q;
        mc_q  <= mc_q << 1;
        mp_q  <= mp_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
  assign fin_o    = act_q && (cnt_q == '0);
  assign prod_o   = acc_q;
endmodule

// File: rtl/muldiv_div_engine.sv
module muldiv_div_engine #(
  parameter int W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       cancel_i,
  input  logic [$clog2(W+1)-1:0]     iters_i,
  input  logic [W-1:0]               dividend_i,
  input  logic [W-1:0]               divisor_i,
  output logic                       active_o,
  output logic                       fin_o,
  output logic [W-1:0]               quo_o,
  output logic [W-1:0]               rem_o
);
  localparam int            CW = $clog2(W+1);
  localparam logic [CW-1:0] WC = CW'(W);

  logic [W-1:0]  dvd_q, dvs_q, quo_q, rem_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [W:0]    trial;
  logic [CW-1:0] align;

  assign align = WC - iters_i;
  assign trial = {rem_q, dvd_q[W-1]} - {1'b0, dvs_q};

  // restoring step: keep the subtraction only when it stays non-negative
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      dvd_q <= dividend_i << align;
      dvs_q <= divisor_i;
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= iters_i;
      act_q <= 1'b1;
    end else if (cancel_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (cnt_q != '0) begin
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= {rem_q[W-2:0], dvd_q[W-1]};
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        dvd_q <= dvd_q << 1;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
  assign fin_o    = act_q && (cnt_q == '0);
  assign quo_o    = quo_q;
  assign rem_o    = rem_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic          wide_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  input  logic          hi_wr_i,
  input  logic          lo_wr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          busy_o,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  lo_o
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(W + 1);

  // ---- arithmetic helpers ----
  function automatic logic [W-1:0] fn_sext(logic [HW-1:0] h);
    return {{HW{h[HW-1]}}, h};
  endfunction

  function automatic logic fn_is_neg(logic [W-1:0] x, logic wide, logic sgn);
    return sgn && (wide ? x[W-1] : x[HW-1]);
  endfunction

  function automatic logic [W-1:0] fn_mag(logic [W-1:0] x, logic wide, logic sgn);
    logic [HW-1:0] xh;
    logic [W-1:0]  r;
    xh = x[HW-1:0];
    if (wide) r = fn_is_neg(x, wide, sgn) ? (~x + 1'b1) : x;
    else      r = {{HW{1'b0}}, (fn_is_neg(x, wide, sgn) ? (~xh + 1'b1) : xh)};
    return r;
  endfunction

  function automatic logic [W-1:0] fn_cneg(logic [W-1:0] x, logic neg);
    return neg ? (~x + 1'b1) : x;
  endfunction

  // ---- command decode ----
  md_op_e        op_in;
  logic          sgn_in, div_in, neg_a, neg_b;
  logic [CW-1:0] iters;
  logic [W-1:0]  mag_a, mag_b;

  assign op_in  = md_op_e'(op_i);
  assign sgn_in = fn_is_signed(op_in);
  assign div_in = fn_is_div(op_in);
  assign neg_a  = fn_is_neg(opa_i, wide_i, sgn_in);
  assign neg_b  = fn_is_neg(opb_i, wide_i, sgn_in);
  assign iters  = wide_i ? CW'(W) : CW'(HW);
  assign mag_a  = fn_mag(opa_i, wide_i, sgn_in);
  assign mag_b  = fn_mag(opb_i, wide_i, sgn_in);

  // ---- latched command context ----
  logic         wide_q, neg_lo_q, neg_hi_q, dz_q;
  logic [W-1:0] dzval_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q   <= 1'b0;
      neg_lo_q <= 1'b0;
      neg_hi_q <= 1'b0;
      dz_q     <= 1'b0;
      dzval_q  <= '0;
    end else if (start_i) begin
      wide_q   <= wide_i;
      neg_lo_q <= neg_a ^ neg_b;
      neg_hi_q <= div_in ? neg_a : (neg_a ^ neg_b);
      dz_q     <= wide_i ? (opb_i == '0) : (opb_i[HW-1:0] == '0);
      dzval_q  <= wide_i ? opa_i : fn_sext(opa_i[HW-1:0]);
    end
  end

  // ---- engines ----
  logic           mul_active, mul_fin, div_active, div_fin;
  logic [2*W-1:0] mul_prod;
  logic [W-1:0]   div_quo, div_rem;

  muldiv_mul_engine #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .load_i(start_i && !div_in), .cancel_i(start_i),
    .iters_i(iters), .mcand_i(mag_a), .mplier_i(mag_b),
    .active_o(mul_active), .fin_o(mul_fin), .prod_o(mul_prod)
  );

  muldiv_div_engine #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .load_i(start_i && div_in), .cancel_i(start_i),
    .iters_i(iters), .dividend_i(mag_a), .divisor_i(mag_b),
    .active_o(div_active), .fin_o(div_fin), .quo_o(div_quo), .rem_o(div_rem)
  );

  // ---- named internal events ----
  logic fin_any, res_we, wr_hi_en, wr_lo_en;
  assign busy_o   = mul_active | div_active;
  assign fin_any  = mul_fin | div_fin;
  assign res_we   = fin_any && !start_i;
  assign wr_hi_en = hi_wr_i && !busy_o && !start_i;
  assign wr_lo_en = lo_wr_i && !busy_o && !start_i;

  // ---- result formatting ----
  logic [2*W-1:0] prod_s;
  logic [W-1:0]   quo_s, rem_s, res_hi, res_lo;

  assign prod_s = neg_lo_q ? (~mul_prod + 1'b1) : mul_prod;
  assign quo_s  = fn_cneg(div_quo, neg_lo_q);
  assign rem_s  = fn_cneg(div_rem, neg_hi_q);

  always_comb begin
    res_hi = '0;
    res_lo = '0;
    if (mul_fin) begin
      if (wide_q) begin
        res_hi = prod_s[2*W-1:W];
        res_lo = prod_s[W-1:0];
      end else begin
        res_hi = fn_sext(prod_s[W-1:HW]);
        res_lo = fn_sext(prod_s[HW-1:0]);
      end
    end else if (div_fin) begin
      if (dz_q) begin
        res_hi = dzval_q;
        res_lo = '1;
      end else if (wide_q) begin
        res_hi = rem_s;
        res_lo = quo_s;
      end else begin
        res_hi = fn_sext(rem_s[HW-1:0]);
        res_lo = fn_sext(quo_s[HW-1:0]);
      end
    end
  end

  // ---- HI / LO registers ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (res_we) begin
      hi_o <= res_hi;
      lo_o <= res_lo;
    end else begin
      if (wr_hi_en) hi_o <= wr_data_i;
      if (wr_lo_en) lo_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         hi_wr_i,
  input logic         lo_wr_i,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o,
  input logic         mul_active,
  input logic         div_active,
  input logic         fin_any,
  input logic         res_we
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_cnt <= 0;
    else if (start_i) busy_cnt <= 0;
    else if (busy_o)  busy_cnt <= busy_cnt + 1;
    else              busy_cnt <= 0;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  p_fin_drops_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_any && !start_i) |=> !busy_o);

  p_latency_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= W + 1);

  p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !res_we) |=> ($stable(hi_o) && $stable(lo_o)));

  p_idle_hi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !hi_wr_i) |=> $stable(hi_o));

  p_idle_lo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !lo_wr_i) |=> $stable(lo_o));

  p_single_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_active && div_active));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .hi_wr_i(hi_wr_i), .lo_wr_i(lo_wr_i),
  .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o),
  .mul_active(mul_active), .div_active(div_active),
  .fin_any(fin_any), .res_we(res_we)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        wide_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0, wr_data_i = '0;
  logic        hi_wr_i = 1'b0, lo_wr_i = 1'b0;
  logic        busy_o;
  logic [63:0] hi_o, lo_o;

  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
    .opa_i(opa_i), .opb_i(opb_i), .hi_wr_i(hi_wr_i), .lo_wr_i(lo_wr_i),
    .wr_data_i(wr_data_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // expected {hi, lo} from wide native arithmetic
  function automatic logic [127:0] ref_res(logic [1:0] op, logic wide, logic [63:0] a, logic [63:0] b);
    logic signed [129:0] xa, xb, p;
    logic signed [65:0]  da, db, q, r;
    logic [63:0]         hi, lo;
    logic                sgn;
    sgn = op[0];
    if (wide) begin
      xa = sgn ? {{66{a[63]}}, a} : {66'b0, a};
      xb = sgn ? {{66{b[63]}}, b} : {66'b0, b};
    end else begin
      xa = sgn ? {{98{a[31]}}, a[31:0]} : {98'b0, a[31:0]};
      xb = sgn ? {{98{b[31]}}, b[31:0]} : {98'b0, b[31:0]};
    end
    if (!op[1]) begin
      p = xa * xb;
      if (wide) begin hi = p[127:64]; lo = p[63:0]; end
      else begin hi = sx32(p[63:32]); lo = sx32(p[31:0]); end
    end else begin
      da = xa[65:0];
      db = xb[65:0];
      if (db == 0) begin
        lo = '1;
        hi = wide ? a : sx32(a[31:0]);
      end else begin
        q = da / db;
        r = da % db;
        if (wide) begin hi = r[63:0]; lo = q[63:0]; end
        else begin hi = sx32(r[31:0]); lo = sx32(q[31:0]); end
      end
    end
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 7)
      0: return 64'd0;
      1: return 64'd1;
      2: return '1;
      3: return 64'h8000_0000_0000_0000;
      4: return {32'hFFFF_FFFF, 32'h8000_0000};
      5: return {32'h0, $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  // pre_k > 0: launch a decoy operation and replace it after pre_k cycles (R9)
  task automatic do_op(input logic [1:0] op, input logic wide, input logic [63:0] a,
                       input logic [63:0] b, input int pre_k, input string tag);
    logic [127:0] exp;
    int n;
    int lat;
    exp = ref_res(op, wide, a, b);
    lat = wide ? 65 : 33;
    if (pre_k > 0) begin
      @(negedge clk);
      start_i = 1'b1; op_i = ~op; wide_i = ~wide; opa_i = b; opb_i = a;
      @(negedge clk);
      start_i = 1'b0;
      repeat (pre_k - 1) @(negedge clk);
    end
    @(negedge clk);
    start_i = 1'b1; op_i = op; wide_i = wide; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " R2 latency"}, 64'(n), 64'(lat));
    chk({tag, " HI"}, hi_o, exp[127:64]);
    chk({tag, " LO"}, lo_o, exp[63:0]);
  endtask

  task automatic dwrite(input logic h, input logic l, input logic [63:0] d);
    @(negedge clk);
    hi_wr_i = h; lo_wr_i = l; wr_data_i = d;
    @(negedge clk);
    hi_wr_i = 1'b0; lo_wr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    logic [63:0] hsave, lsave;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 HI", hi_o, 64'd0);
    chk("R1 LO", lo_o, 64'd0);

    // R8 direct writes while idle
    dwrite(1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0);
    chk("R8 HI write", hi_o, 64'h1234_5678_9ABC_DEF0);
    chk("R8 LO untouched", lo_o, 64'd0);
    dwrite(1'b0, 1'b1, 64'h0FED_CBA9_8765_4321);
    chk("R8 LO write", lo_o, 64'h0FED_CBA9_8765_4321);
    chk("R8 HI kept", hi_o, 64'h1234_5678_9ABC_DEF0);

    // R3 multiplies
    do_op(2'b00, 1'b1, '1, '1, 0, "R3 mulu64 max");
    do_op(2'b01, 1'b1, '1, '1, 0, "R3 muls64 -1*-1");
    do_op(2'b01, 1'b1, 64'h8000_0000_0000_0000, 64'd3, 0, "R3 muls64 min*3");
    // R5 32-bit mode: upper garbage ignored, results sign-extended
    do_op(2'b00, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF, 64'hCAFE_0000_FFFF_FFFF, 0, "R5 mulu32");
    do_op(2'b01, 1'b0, 64'h1111_1111_FFFF_FFFE, 64'h2222_2222_0000_0003, 0, "R5 muls32");

    // R4 signed divide, checked against literal values too
    do_op(2'b11, 1'b1, -64'sd7, 64'd2, 0, "R4 divs64 -7/2");
    chk("R4 quotient -3", lo_o, 64'hFFFF_FFFF_FFFF_FFFD);
    chk("R4 remainder -1", hi_o, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(2'b11, 1'b0, 64'd7, {32'h5, 32'hFFFF_FFFE}, 0, "R4 R5 divs32 7/-2");
    do_op(2'b10, 1'b1, '1, 64'd10, 0, "R4 divu64");

    // R6 divide by zero
    do_op(2'b10, 1'b1, 64'h0123_4567_89AB_CDEF, 64'd0, 0, "R6 divu64 by0");
    chk("R6 LO ones", lo_o, '1);
    do_op(2'b11, 1'b0, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_0000_0000, 0, "R6 divs32 by0");

    // R10 signed overflow
    do_op(2'b11, 1'b1, 64'h8000_0000_0000_0000, '1, 0, "R10 divs64 min/-1");
    do_op(2'b11, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, "R10 divs32 min/-1");
    chk("R10 LO", lo_o, 64'hFFFF_FFFF_8000_0000);

    // R7 write strobes while busy are ignored
    hsave = hi_o; lsave = lo_o;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'b10; wide_i = 1'b1; opa_i = 64'd1000; opb_i = 64'd7;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    hi_wr_i = 1'b1; lo_wr_i = 1'b1; wr_data_i = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk);
    hi_wr_i = 1'b0; lo_wr_i = 1'b0;
    chk("R7 HI held", hi_o, hsave);
    chk("R7 LO held", lo_o, lsave);
    while (busy_o) @(negedge clk);
    chk("R7 quotient", lo_o, 64'd142);
    chk("R7 remainder", hi_o, 64'd6);

    // R8 write with start in same cycle ignored
    hsave = hi_o; lsave = lo_o;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'b00; wide_i = 1'b0; opa_i = 64'd3; opb_i = 64'd5;
    hi_wr_i = 1'b1; lo_wr_i = 1'b1; wr_data_i = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    start_i = 1'b0; hi_wr_i = 1'b0; lo_wr_i = 1'b0;
    chk("R8 start-write HI", hi_o, hsave);
    chk("R8 start-write LO", lo_o, lsave);
    while (busy_o) @(negedge clk);
    chk("R8 then R3 LO", lo_o, 64'd15);

    // R9 restart partway through
    do_op(2'b00, 1'b0, 64'd12345, 64'd678, 10, "R9 restart mul32");
    do_op(2'b11, 1'b1, -64'sd100, 64'd9, 25, "R9 restart divs64");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0]  rop;
      logic        rw;
      logic [63:0] ra, rb;
      int          pk;
      rop = 2'($urandom);
      rw  = 1'($urandom);
      ra  = pick();
      rb  = pick();
      pk  = (($urandom % 8) == 0) ? 1 + int'($urandom % 30) : 0;
      do_op(rop, rw, ra, rb, pk, pk > 0 ? "R9 rand" : (rop[1] ? "R4 rand" : "R3 rand"));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule